// File: doc/BRIEF.md
# Partitioned Record Search Engine

This block looks up one record in a database kept in external memory that is read 64 bits at a time. The database is split into ten partitions. Each partition has a base word address and a record count, and both arrive on configuration inputs. A query brings a source IPv4 address and a match key. The engine picks a partition from the decimal digits of the address's leading octet. It then probes that partition's records one by one, starting with the first. For each record it fetches only the key words. When a record's key equals the query key, it fetches the rest of that record and streams it out. The engine then ends the query with a one-cycle result pulse.

A second mode ignores the address. It walks one contiguous region, described by its own base and count, from first record to last. Only one query is in flight at a time. The engine accepts a query through a valid/ready handshake and returns to ready on the cycle after the result pulse.

The control is a seven-state machine:
- IDLE waits for a query.
- KEY_REQ issues the key fetch.
- KEY_WAIT gathers the key beats.
- CHECK compares the key.
- BODY_REQ issues the fetch of the record's remainder.
- BODY_WAIT forwards the remainder beats.
- FINISH raises the result pulse.

The transitions are:
- IDLE to KEY_REQ when a query arrives and the selected count is nonzero.
- IDLE to FINISH when a query arrives and the selected count is zero.
- KEY_REQ to KEY_WAIT.
- KEY_WAIT to CHECK on the last key beat.
- CHECK to BODY_REQ on a hit.
- CHECK to KEY_REQ on a miss while records remain.
- CHECK to FINISH on a miss at the last record.
- BODY_REQ to BODY_WAIT.
- BODY_WAIT to FINISH on the last remainder beat.
- FINISH to IDLE.

Top module: `pse_search`

## Requirements
- R1: The partition number is formed from bits 31:24 of the source address. Take the hundreds, tens and units digits of that octet, add them, and keep adding the digits of the sum until one digit (0 to 9) remains. That digit is reported on `res_part` with the result pulse. Examples: 192 gives 3, 199 gives 1, 0 gives 0.
- R2: In partitioned mode, record r of partition p starts at word `base[p] + r*13`. The base of partition p is `cfg_part_base[p*16 +: 16]` and its count is `cfg_part_cnt[p*8 +: 8]`. Records are probed in increasing r. The first record whose key matches is reported with `found`=1 and its start word on `match_addr`. Records outside the selected partition are never reported.
- R3: The key of a record is the low 129 bits of its first three words, with word 0 least significant. The bits above bit 128 in the third word do not take part in the comparison. A difference in any of the 129 key bits, including bit 0 and bit 128, is a mismatch.
- R4: Each probe issues a one-cycle `mem_req` with `mem_len`=3 at the record's start word. Only after a hit is a second request issued, with `mem_len`=10 at start word + 3. No other lengths occur.
- R5: After a hit, the ten remainder words appear on `rec_data` with `rec_valid`, in increasing address order. They all appear before the result pulse.
- R6: If no record matches, the pulse carries `found`=0 after exactly `count` probes, and no remainder is fetched. With a count of zero, the pulse comes in the first cycle after acceptance and no memory request is made.
- R7: With `q_linear`=1, the search walks `cfg_lin_cnt` records from `cfg_lin_base` with the same 13-word stride. The address is ignored and `res_part` reports 10.
- R8: After reset, `q_ready`=1, `done`=0 and `mem_req`=0. `q_ready` is low from the cycle after acceptance until the cycle after the single-cycle `done` pulse.
- R9: Each probe takes one request cycle, the cycles until its last key beat arrives, and one compare cycle. `done` rises in the cycle after the final compare on a miss, or in the cycle after the last remainder beat on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Engine idle, query accepted when valid |
| q_src_ip | input | 32 | Source IPv4 address of the query |
| q_key | input | 129 | Match key of the query |
| q_linear | input | 1 | 1 selects the whole-region linear walk |
| cfg_part_base | input | 160 | Ten 16-bit partition base word addresses |
| cfg_part_cnt | input | 80 | Ten 8-bit partition record counts |
| cfg_lin_base | input | 16 | Base word address for linear mode |
| cfg_lin_cnt | input | 8 | Record count for linear mode |
| mem_req | output | 1 | One-cycle burst read request |
| mem_addr | output | 16 | First word address of the burst |
| mem_len | output | 4 | Number of 64-bit beats requested |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 64 | Read beat data |
| rec_valid | output | 1 | Remainder beat of the matched record valid |
| rec_data | output | 64 | Remainder beat data |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | Match found, valid with done |
| match_addr | output | 16 | Start word of the matched record, valid with done and found |
| res_part | output | 4 | Partition searched (10 in linear mode), valid with done |

## Verification
Result timing depends on the memory's first-beat delay. The bench's memory model returns the first beat two cycles after it sees a request and each later beat one cycle after the one before. With that model, an empty search pulses `done` in the first cycle after acceptance. A miss over n records pulses after 6n+1 cycles. A hit at record m pulses after 6(m+1)+13 cycles, counting the acceptance edge as cycle zero. The bench samples all outputs once per cycle, two time units after the falling edge, when memory data and state belong to the same cycle. It counts those samples from acceptance and compares the sample at which `done` appears against these figures. Remainder beats are checked at the samples where `rec_valid` is high, before `done`.

// File: rtl/pse_pkg.sv
package pse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY_REQ,
        ST_KEY_WAIT,
        ST_CHECK,
        ST_BODY_REQ,
        ST_BODY_WAIT,
        ST_FINISH
    } pse_state_e;

    // Decimal digit roots span 0..9, so the partition count is fixed.
    localparam int PSE_NUM_PART = 10;
    localparam int PSE_PART_W   = 4;

endpackage

// File: rtl/pse_part_sel.sv
module pse_part_sel
    import pse_pkg::*;
(
    input  logic [7:0]            octet_i,
    output logic [PSE_PART_W-1:0] part_o
);

    logic [7:0] hund;
    logic [7:0] rest;
    logic [7:0] tens;
    logic [7:0] ones;
    logic [7:0] sum0;
    logic [7:0] sum1;

    // Binary octet to decimal digits, then two rounds of digit folding
    // (max first sum is 19, which needs the second round).
    always_comb begin
        hund   = octet_i / 8'd100;
        rest   = octet_i % 8'd100;
        tens   = rest / 8'd10;
        ones   = rest % 8'd10;
        sum0   = hund + tens + ones;
        sum1   = (sum0 / 8'd10) + (sum0 % 8'd10);
        part_o = PSE_PART_W'((sum1 / 8'd10) + (sum1 % 8'd10));
    end

endmodule

// File: rtl/pse_key_cmp.sv
module pse_key_cmp #(
    parameter int BUS_W     = 64,
    parameter int KEY_W     = 129,
    parameter int KEY_BEATS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [KEY_W-1:0] query_i,
    input  logic             beat_en_i,
    input  logic [BUS_W-1:0] beat_i,
    output logic             match_o
);

    localparam int FULL_W = KEY_BEATS * BUS_W;

    logic [KEY_W-1:0]  qkey_q;
    logic [FULL_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qkey_q <= '0;
        end else if (load_i) begin
            qkey_q <= query_i;
        end
    end

    // Beats enter at the top and move down, so beat 0 ends in the low word.
    generate
        if (KEY_BEATS > 1) begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    win_q <= '0;
                end else if (beat_en_i) begin
                    win_q <= {beat_i, win_q[FULL_W-1:BUS_W]};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    win_q <= '0;
                end else if (beat_en_i) begin
                    win_q <= beat_i;
                end
            end
        end
    endgenerate

    generate
        if (FULL_W > KEY_W) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^win_q[FULL_W-1:KEY_W];
            assign match_o    = (win_q[KEY_W-1:0] == qkey_q);
        end else begin : g_exact
            assign match_o = (win_q == qkey_q);
        end
    endgenerate

endmodule

// File: rtl/pse_ctrl.sv
module pse_ctrl
    import pse_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int LEN_W      = 4,
    parameter int KEY_BEATS  = 3,
    parameter int BODY_BEATS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  q_valid_i,
    output logic                  q_ready_o,
    input  logic [ADDR_W-1:0]     sel_base_i,
    input  logic [CNT_W-1:0]      sel_cnt_i,
    input  logic [PSE_PART_W-1:0] part_i,
    input  logic                  key_match_i,
    output logic                  key_beat_en_o,
    output logic                  mem_req_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [LEN_W-1:0]      mem_len_o,
    input  logic                  mem_rvalid_i,
    output logic                  rec_valid_o,
    output logic                  done_o,
    output logic                  found_o,
    output logic [ADDR_W-1:0]     match_addr_o,
    output logic [PSE_PART_W-1:0] part_o
);

    localparam int              REC_BEATS = KEY_BEATS + BODY_BEATS;
    localparam logic [LEN_W-1:0] KEY_LAST  = LEN_W'(KEY_BEATS - 1);
    localparam logic [LEN_W-1:0] BODY_LAST = LEN_W'((BODY_BEATS > 0) ? BODY_BEATS - 1 : 0);

    pse_state_e              state_q;
    pse_state_e              state_d;
    logic [ADDR_W-1:0]       addr_q;
    logic [CNT_W-1:0]        left_q;
    logic [LEN_W-1:0]        beat_q;
    logic                    found_q;
    logic [PSE_PART_W-1:0]   part_q;
    logic                    accept;
    logic                    key_last;
    logic                    body_last;

    assign accept    = q_valid_i && (state_q == ST_IDLE);
    assign key_last  = mem_rvalid_i && (beat_q == KEY_LAST);
    assign body_last = mem_rvalid_i && (beat_q == BODY_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (q_valid_i) begin
                    state_d = (sel_cnt_i == '0) ? ST_FINISH : ST_KEY_REQ;
                end
            end
            ST_KEY_REQ:  state_d = ST_KEY_WAIT;
            ST_KEY_WAIT: begin
                if (key_last) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (key_match_i) begin
                    state_d = (BODY_BEATS > 0) ? ST_BODY_REQ : ST_FINISH;
                end else if (left_q == CNT_W'(1)) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_KEY_REQ;
                end
            end
            ST_BODY_REQ:  state_d = ST_BODY_WAIT;
            ST_BODY_WAIT: begin
                if (body_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        q_ready_o     = (state_q == ST_IDLE);
        mem_req_o     = (state_q == ST_KEY_REQ) || (state_q == ST_BODY_REQ);
        mem_addr_o    = (state_q == ST_BODY_REQ) ? addr_q + ADDR_W'(KEY_BEATS) : addr_q;
        mem_len_o     = (state_q == ST_BODY_REQ) ? LEN_W'(BODY_BEATS) : LEN_W'(KEY_BEATS);
        key_beat_en_o = (state_q == ST_KEY_WAIT) && mem_rvalid_i;
        rec_valid_o   = (state_q == ST_BODY_WAIT) && mem_rvalid_i;
        done_o        = (state_q == ST_FINISH);
        found_o       = found_q;
        match_addr_o  = addr_q;
        part_o        = part_q;
    end

    // Walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            left_q  <= '0;
            beat_q  <= '0;
            found_q <= 1'b0;
            part_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= sel_base_i;
                left_q  <= sel_cnt_i;
                found_q <= 1'b0;
                part_q  <= part_i;
            end
            if ((state_q == ST_KEY_REQ) || (state_q == ST_BODY_REQ)) begin
                beat_q <= '0;
            end else if (mem_rvalid_i) begin
                beat_q <= beat_q + LEN_W'(1);
            end
            if (state_q == ST_CHECK) begin
                if (key_match_i) begin
                    found_q <= 1'b1;
                end else begin
                    addr_q <= addr_q + ADDR_W'(REC_BEATS);
                    left_q <= left_q - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pse_search.sv
module pse_search
    import pse_pkg::*;
#(
    parameter int BUS_W  = 64,
    parameter int KEY_W  = 129,
    parameter int REC_W  = 792,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          q_valid,
    output logic                          q_ready,
    input  logic [31:0]                   q_src_ip,
    input  logic [KEY_W-1:0]              q_key,
    input  logic                          q_linear,
    input  logic [PSE_NUM_PART*ADDR_W-1:0] cfg_part_base,
    input  logic [PSE_NUM_PART*CNT_W-1:0]  cfg_part_cnt,
    input  logic [ADDR_W-1:0]             cfg_lin_base,
    input  logic [CNT_W-1:0]              cfg_lin_cnt,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [$clog2(((REC_W+BUS_W-1)/BUS_W)+1)-1:0] mem_len,
    input  logic                          mem_rvalid,
    input  logic [BUS_W-1:0]              mem_rdata,
    output logic                          rec_valid,
    output logic [BUS_W-1:0]              rec_data,
    output logic                          done,
    output logic                          found,
    output logic [ADDR_W-1:0]             match_addr,
    output logic [PSE_PART_W-1:0]         res_part
);

    localparam int KEY_BEATS  = (KEY_W + BUS_W - 1) / BUS_W;
    localparam int REC_BEATS  = (REC_W + BUS_W - 1) / BUS_W;
    localparam int BODY_BEATS = REC_BEATS - KEY_BEATS;
    localparam int LEN_W      = $clog2(REC_BEATS + 1);

    logic [ADDR_W-1:0]     base_arr [PSE_NUM_PART];
    logic [CNT_W-1:0]      cnt_arr  [PSE_NUM_PART];
    logic [PSE_PART_W-1:0] part_w;
    logic [PSE_PART_W-1:0] part_sel;
    logic [ADDR_W-1:0]     sel_base;
    logic [CNT_W-1:0]      sel_cnt;
    logic                  key_match;
    logic                  key_beat_en;
    logic                  key_load;
    logic                  unused_ip_low;

    assign unused_ip_low = ^q_src_ip[23:0];

    generate
        for (genvar g = 0; g < PSE_NUM_PART; g++) begin : g_cfg
            assign base_arr[g] = cfg_part_base[g*ADDR_W +: ADDR_W];
            assign cnt_arr[g]  = cfg_part_cnt[g*CNT_W +: CNT_W];
        end
    endgenerate

    pse_part_sel u_part (
        .octet_i (q_src_ip[31:24]),
        .part_o  (part_w)
    );

    assign sel_base = q_linear ? cfg_lin_base : base_arr[part_w];
    assign sel_cnt  = q_linear ? cfg_lin_cnt  : cnt_arr[part_w];
    assign part_sel = q_linear ? PSE_PART_W'(PSE_NUM_PART) : part_w;
    assign key_load = q_valid && q_ready;
    assign rec_data = mem_rdata;

    pse_key_cmp #(
        .BUS_W     (BUS_W),
        .KEY_W     (KEY_W),
        .KEY_BEATS (KEY_BEATS)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (key_load),
        .query_i   (q_key),
        .beat_en_i (key_beat_en),
        .beat_i    (mem_rdata),
        .match_o   (key_match)
    );

    pse_ctrl #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .KEY_BEATS  (KEY_BEATS),
        .BODY_BEATS (BODY_BEATS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_valid_i     (q_valid),
        .q_ready_o     (q_ready),
        .sel_base_i    (sel_base),
        .sel_cnt_i     (sel_cnt),
        .part_i        (part_sel),
        .key_match_i   (key_match),
        .key_beat_en_o (key_beat_en),
        .mem_req_o     (mem_req),
        .mem_addr_o    (mem_addr),
        .mem_len_o     (mem_len),
        .mem_rvalid_i  (mem_rvalid),
        .rec_valid_o   (rec_valid),
        .done_o        (done),
        .found_o       (found),
        .match_addr_o  (match_addr),
        .part_o        (res_part)
    );

endmodule

// File: rtl/pse_search_chk.sv
module pse_search_chk #(
    parameter int LEN_W      = 4,
    parameter int KEY_BEATS  = 3,
    parameter int BODY_BEATS = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q_valid,
    input logic             q_ready,
    input logic             mem_req,
    input logic [LEN_W-1:0] mem_len,
    input logic             rec_valid,
    input logic             done,
    input logic             found,
    input logic [3:0]       res_part
);

    AST_PART_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_part <= 4'd10)) else $error("part out of range"); // R1

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_len == LEN_W'(KEY_BEATS)) || (mem_len == LEN_W'(BODY_BEATS))))
        else $error("illegal burst length"); // R4

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) else $error("request longer than one cycle"); // R4

    AST_HIT_AFTER_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> $past(rec_valid)) else $error("hit without remainder"); // R5

    AST_MISS_NO_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> !$past(rec_valid)) else $error("remainder on miss"); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready) |=> !q_ready) else $error("ready while busy"); // R8

    AST_REQ_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rec_valid || done) |-> !q_ready) else $error("activity while idle"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && q_ready)) else $error("done not a pulse"); // R8

endmodule

bind pse_search pse_search_chk #(
    .LEN_W      (LEN_W),
    .KEY_BEATS  (KEY_BEATS),
    .BODY_BEATS (BODY_BEATS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_valid   (q_valid),
    .q_ready   (q_ready),
    .mem_req   (mem_req),
    .mem_len   (mem_len),
    .rec_valid (rec_valid),
    .done      (done),
    .found     (found),
    .res_part  (res_part)
);

// File: tb/pse_search_tb.sv
module pse_search_tb;

    localparam int CLK_PERIOD = 10;
    localparam int KEY_W      = 129;
    localparam int BUS_W      = 64;
    localparam int ADDR_W     = 16;
    localparam int CNT_W      = 8;
    localparam int NP         = 10;
    localparam int KB         = 3;
    localparam int BB         = 10;
    localparam int RB         = 13;
    localparam int MEM_LAT    = 2;
    localparam int STEP       = 1 + MEM_LAT + KB;
    localparam int LIN_BASE   = 1000;
    localparam int LIN_CNT    = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 q_valid = 1'b0;
    logic                 q_ready;
    logic [31:0]          q_src_ip = '0;
    logic [KEY_W-1:0]     q_key = '0;
    logic                 q_linear = 1'b0;
    logic [NP*ADDR_W-1:0] cfg_part_base = '0;
    logic [NP*CNT_W-1:0]  cfg_part_cnt = '0;
    logic [ADDR_W-1:0]    cfg_lin_base = ADDR_W'(LIN_BASE);
    logic [CNT_W-1:0]     cfg_lin_cnt = CNT_W'(LIN_CNT);
    logic                 mem_req;
    logic [ADDR_W-1:0]    mem_addr;
    logic [3:0]           mem_len;
    logic                 mem_rvalid = 1'b0;
    logic [BUS_W-1:0]     mem_rdata = '0;
    logic                 rec_valid;
    logic [BUS_W-1:0]     rec_data;
    logic                 done;
    logic                 found;
    logic [ADDR_W-1:0]    match_addr;
    logic [3:0]           res_part;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int kreq_n = 0;
    int breq_n = 0;
    int breq_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pse_search #(
        .BUS_W  (BUS_W),
        .KEY_W  (KEY_W),
        .REC_W  (792),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_valid       (q_valid),
        .q_ready       (q_ready),
        .q_src_ip      (q_src_ip),
        .q_key         (q_key),
        .q_linear      (q_linear),
        .cfg_part_base (cfg_part_base),
        .cfg_part_cnt  (cfg_part_cnt),
        .cfg_lin_base  (cfg_lin_base),
        .cfg_lin_cnt   (cfg_lin_cnt),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_len       (mem_len),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .rec_valid     (rec_valid),
        .rec_data      (rec_data),
        .done          (done),
        .found         (found),
        .match_addr    (match_addr),
        .res_part      (res_part)
    );

    function automatic logic [63:0] word_at(input int a);
        logic [15:0] w;
        w = 16'(a);
        return {w ^ 16'h5A3C, 16'hC0DE, ~w, w};
    endfunction

    function automatic logic [KEY_W-1:0] key_at(input int ra);
        logic [63:0] w0;
        logic [63:0] w1;
        logic [63:0] w2;
        w0 = word_at(ra);
        w1 = word_at(ra + 1);
        w2 = word_at(ra + 2);
        return {w2[0], w1, w0};
    endfunction

    function automatic int root_of(input int o);
        int s;
        s = o / 100 + (o / 10) % 10 + o % 10;
        while (s > 9) s = s / 10 + s % 10;
        return s;
    endfunction

    function automatic int oct_for(input int p);
        for (int o = 0; o < 256; o++) begin
            if (root_of(o) == p) return o;
        end
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory model: first beat MEM_LAT cycles after the request is seen,
    // then one beat per cycle.
    initial begin
        int lat_c;
        int addr_c;
        int left_c;
        lat_c = 0;
        addr_c = 0;
        left_c = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (lat_c > 1) begin
                lat_c--;
            end else if (lat_c == 1) begin
                mem_rvalid = 1'b1;
                mem_rdata  = word_at(addr_c);
                addr_c++;
                left_c--;
                if (left_c == 0) lat_c = 0;
            end
            if (mem_req === 1'b1) begin
                lat_c  = MEM_LAT;
                addr_c = int'(mem_addr);
                left_c = int'(mem_len);
                if (mem_len == 4'(KB)) kreq_n++;
                else begin
                    breq_n++;
                    breq_addr = int'(mem_addr);
                end
            end
        end
    end

    task automatic set_cfg(input bit empty);
        for (int p = 0; p < NP; p++) begin
            cfg_part_base[p*ADDR_W +: ADDR_W] = ADDR_W'(p * 64);
            cfg_part_cnt[p*CNT_W +: CNT_W]    = empty ? '0 : CNT_W'(p % 4);
        end
    endtask

    task automatic run_query(input int oct, input logic [KEY_W-1:0] key, input bit lin,
                             input bit ef, input int eaddr, input int epart,
                             input int ecyc, input int ekreq, input string req);
        int cyc;
        int nrec;
        bit got;
        @(negedge clk); #2;
        chk(q_ready == 1'b1, "R8", "ready before query", q_ready, 1);
        q_valid  = 1'b1;
        q_src_ip = {8'(oct), 24'h3A7F11};
        q_key    = key;
        q_linear = lin;
        kreq_n = 0;
        breq_n = 0;
        @(negedge clk); #2;
        q_valid = 1'b0;
        cyc = 1;
        nrec = 0;
        got = 1'b0;
        if (ecyc > 1) chk(q_ready == 1'b0, "R8", "busy after accept", q_ready, 0);
        while (!got && cyc < 2000) begin
            if (rec_valid) begin
                chk(rec_data == word_at(eaddr + KB + nrec), "R5", "remainder beat",
                    longint'(rec_data), longint'(word_at(eaddr + KB + nrec)));
                nrec++;
            end
            if (done) got = 1'b1;
            else begin
                @(negedge clk); #2;
                cyc++;
            end
        end
        chk(got, req, "done seen", got, 1);
        chk(found == ef, req, "found", found, ef);
        if (ef) chk(int'(match_addr) == eaddr, "R2", "match address", match_addr, eaddr);
        chk(int'(res_part) == epart, lin ? "R7" : "R1", "partition", res_part, epart);
        chk(cyc == ecyc, "R9", "done cycle", cyc, ecyc);
        chk(nrec == (ef ? BB : 0), "R5", "remainder beat count", nrec, ef ? BB : 0);
        chk(kreq_n == ekreq, "R4", "key requests", kreq_n, ekreq);
        chk(breq_n == (ef ? 1 : 0), "R4", "body requests", breq_n, ef ? 1 : 0);
        if (ef) chk(breq_addr == eaddr + KB, "R4", "body address", breq_addr, eaddr + KB);
    endtask

    initial begin
        logic [KEY_W-1:0] one;
        one = 1;
        set_cfg(1'b1);
        repeat (3) @(negedge clk);
        #2;
        chk(q_ready == 1'b1, "R8", "reset ready", q_ready, 1);
        chk(done == 1'b0, "R8", "reset done", done, 0);
        chk(mem_req == 1'b0, "R8", "reset mem_req", mem_req, 0);
        rst_n = 1'b1;

        // Every octet against empty partitions: partition number and
        // immediate not-found (R1, R6).
        for (int o = 0; o < 256; o++) begin
            run_query(o, '0, 1'b0, 1'b0, 0, root_of(o), 1, 0, "R6");
        end

        set_cfg(1'b0);
        for (int p = 0; p < NP; p++) begin
            int oct;
            int n;
            int base;
            oct  = oct_for(p);
            n    = p % 4;
            base = p * 64;
            for (int m = 0; m < n; m++) begin
                run_query(oct, key_at(base + m*RB), 1'b0, 1'b1, base + m*RB, p,
                          STEP*(m+1) + MEM_LAT + BB + 1, m + 1, "R2");
            end
            if (n == 0) begin
                run_query(oct, key_at(base), 1'b0, 1'b0, 0, p, 1, 0, "R6");
            end else begin
                run_query(oct, key_at(base) ^ (one << 128), 1'b0, 1'b0, 0, p,
                          STEP*n + 1, n, "R3");
                run_query(oct, key_at(base) ^ one, 1'b0, 1'b0, 0, p,
                          STEP*n + 1, n, "R3");
            end
        end

        // A record of partition 2 looked up with an octet of partition 3.
        run_query(oct_for(3), key_at(2*64), 1'b0, 1'b0, 0, 3, STEP*3 + 1, 3, "R2");

        // Linear walk over its own region.
        for (int m = 0; m < LIN_CNT; m++) begin
            run_query(oct_for(7), key_at(LIN_BASE + m*RB), 1'b1, 1'b1, LIN_BASE + m*RB,
                      10, STEP*(m+1) + MEM_LAT + BB + 1, m + 1, "R7");
        end
        run_query(oct_for(1), key_at(64), 1'b1, 1'b0, 0, 10, STEP*LIN_CNT + 1,
                  LIN_CNT, "R7");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule